// File: doc/BRIEF.md
# Watchdog Timer with Selectable Period

This block is a watchdog for a processor subsystem. A binary counter runs on the system clock. If software does not restart it within the chosen detection interval, the block raises a one-cycle request on a non-maskable interrupt line. It also pulls an active-low timeout pin low, and the pin stays low until software clears the counter. Software picks one of six power-of-two intervals through a write port. The same write port carries a restart command, an idle-run bit and a keyed disable.

The counter runs from the moment reset is released. Its behaviour depends on the power and debug state. It never advances while the stop, sleep or slow mode input is high, because the fast clock is absent in those modes. In idle mode it runs only when software has set the idle-run bit. While a debug halt is in force it holds its value, and it continues from that value when the halt ends.

Top module: `wdog_timer`

## Requirements
- R1: While reset is held and right after it is released, the watchdog is enabled, the period code is 0, the idle-run bit is 0, the counter is 0, `nmi_req_o` is 0 and `tout_n_o` is 1.
- R2: Period code c (0 to 5) on `wr_period` selects an interval of 2^(BASE_EXP + EXP_STEP*c) counting cycles. With the defaults these are 2^15, 2^17, 2^19, 2^21, 2^23 and 2^25 cycles. Codes 6 and 7 select the same interval as code 5.
- R3: `nmi_req_o` is high for exactly one cycle. That cycle follows the clock edge on which the counter completes the selected number of counting cycles. The counter then restarts from zero, so without a clear the pulse repeats once every interval.
- R4: `tout_n_o` goes low in the same cycle as the interrupt pulse and stays low until a clear or a reset.
- R5: A write with `wr_clear`=1 sets the counter to zero and returns `tout_n_o` to 1. The clear wins over a timeout that falls on the same edge, and in that case no pulse is issued.
- R6: A write whose `wr_period` differs from the stored code also restarts the counter from zero, so the new interval is measured in full.
- R7: A write disables the watchdog only when it has `wr_run_en`=0 and `wr_key` equal to DISABLE_KEY (default 8'hB1). A write with `wr_run_en`=0 and any other key leaves the watchdog running. While disabled, no pulse is issued and the pin stays high. A write with `wr_run_en`=1 re-enables the watchdog and counts from zero.
- R8: While `idle_i` is high, the counter advances only if the stored idle-run bit is 1. Otherwise it holds its value.
- R9: While any of `stop_i`, `sleep_i` or `slow_i` is high, the counter holds its value, even when idle-run is set.
- R10: While `dbg_halt_i` is high, the counter holds its value, and it resumes from that value when the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write strobe for the control fields below |
| wr_run_en | input | 1 | Run enable field |
| wr_period | input | SEL_W (3) | Period code field |
| wr_idle_run | input | 1 | Keep counting in idle mode |
| wr_clear | input | 1 | Restart-the-counter command |
| wr_key | input | KEY_W (8) | Key that must match DISABLE_KEY to disable |
| idle_i | input | 1 | Idle mode is active |
| stop_i | input | 1 | Stop mode is active |
| sleep_i | input | 1 | Sleep mode is active |
| slow_i | input | 1 | Slow-clock mode is active |
| dbg_halt_i | input | 1 | Processor is halted by the debugger |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |
| tout_n_o | output | 1 | Timeout pin, active low, held until a clear |

## Verification
The bench uses short intervals so that each timeout is reached in full. For each timeout it checks that the pulse is absent one cycle early and present on the exact cycle. This separates a correct terminal compare from an off-by-one, and it separates period codes 0, 1, 2 and 7 from one another. Some runs are interrupted by idle, by each low-power mode and by debug halt. Because the expected pulse cycle moves by exactly the number of halted cycles, a hold can be told apart from a counter reset and from no gating at all. Further writes land a clear on the terminal edge, disable with a wrong key and then with the right one, and change the period partway through a run. These show whether the clear has priority, whether the key is checked, and whether a period change restarts the interval.

// File: rtl/wdog_pkg.sv
// Package for the watchdog: types and helpers shared by its submodules.
// Assumes the exponents it is given stay below 64.
package wdog_pkg;

    // Power and debug state of the core, gathered into one struct.
    typedef struct packed {
        logic idle;
        logic stop;
        logic sleep;
        logic slow;
        logic dbg;
    } wdog_mode_t;

    // Terminal count for an interval of 2^exp cycles, counted from zero.
    function automatic logic [63:0] term_of(input int unsigned exp);
        return (64'd1 << exp) - 64'd1;
    endfunction

endpackage

// File: rtl/wdog_ctrl.sv
// Control register for the watchdog.
// Stores the run enable, the period code and the idle-run bit.
// Produces the counter-restart request for clear commands, period changes,
//   keyed disables and re-enables.
// Assumes at most one write per cycle. A write always carries every field.
module wdog_ctrl #(
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned KEY_W       = 8,
    parameter logic [KEY_W-1:0] DISABLE_KEY = 8'hB1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_run_en,
    input  logic [SEL_W-1:0] wr_period,
    input  logic             wr_idle_run,
    input  logic             wr_clear,
    input  logic [KEY_W-1:0] wr_key,
    output logic             run_en,
    output logic [SEL_W-1:0] period_q,
    output logic             idle_run_q,
    output logic             cnt_clear
);

    logic key_ok;
    logic disable_hit;
    logic enable_hit;
    logic period_chg;

    // Decode which effects the current write has.
    always_comb begin
        key_ok      = (wr_key == DISABLE_KEY);
        disable_hit = wr_valid && !wr_run_en && key_ok && run_en;
        enable_hit  = wr_valid && wr_run_en && !run_en;
        period_chg  = wr_valid && (wr_period != period_q);
        cnt_clear   = (wr_valid && wr_clear) || period_chg || disable_hit || enable_hit;
    end

    // Update the stored fields. The enable resets to 1 so the watchdog runs from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en     <= 1'b1;
            period_q   <= '0;
            idle_run_q <= 1'b0;
        end else if (wr_valid) begin
            period_q   <= wr_period;
            idle_run_q <= wr_idle_run;
            if (wr_run_en)
                run_en <= 1'b1;
            else if (key_ok)
                run_en <= 1'b0;
        end
    end

    // R7: the enable falls only after a write with a zero enable and the matching key
    p_disable_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_en) |-> $past(wr_valid && !wr_run_en && (wr_key == DISABLE_KEY)));

    // R6: a write that changes the period code raises a restart
    p_period_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_period != period_q)) |-> cnt_clear);

endmodule

// File: rtl/wdog_gate.sv
// Decides in each cycle whether the watchdog counter may advance.
// Low-power modes and debug halt always block it. Idle blocks it unless
//   idle-run is set.
// Assumes the mode inputs are already synchronous to clk.
module wdog_gate
    import wdog_pkg::*;
(
    input  logic       run_en,
    input  logic       idle_run,
    input  wdog_mode_t mode,
    output logic       advance
);

    logic no_fast_clk;
    logic idle_block;

    // Combine the enable with the gating conditions of each mode.
    always_comb begin
        no_fast_clk = mode.stop || mode.sleep || mode.slow;
        idle_block  = mode.idle && !idle_run;
        advance     = run_en && !no_fast_clk && !idle_block && !mode.dbg;
    end

endmodule

// File: rtl/wdog_counter.sv
// Binary counter with a terminal count chosen by the period code.
// On the terminal edge it wraps to zero, sends a one-cycle request and
//   latches the timeout pin low.
// Assumes every interval is at least two cycles. A restart has priority over
//   a timeout on the same edge.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_EXP    = 15,
    parameter int unsigned EXP_STEP    = 2,
    parameter int unsigned NUM_PERIODS = 6,
    parameter int unsigned SEL_W       = 3,
    localparam int unsigned CNT_W      = BASE_EXP + EXP_STEP * (NUM_PERIODS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             cnt_clear,
    input  logic [SEL_W-1:0] period_sel,
    output logic             nmi_req,
    output logic             tout_n
);

    logic [CNT_W-1:0] term_tab [NUM_PERIODS];
    logic [SEL_W-1:0] sel_idx;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] count;

    // Build one terminal value per period code.
    for (genvar gi = 0; gi < NUM_PERIODS; gi++) begin : g_term
        localparam logic [63:0] TV = term_of(BASE_EXP + EXP_STEP * gi);
        assign term_tab[gi] = TV[CNT_W-1:0];
    end

    // Map codes past the last period onto the longest interval.
    always_comb begin
        if (period_sel > SEL_W'(NUM_PERIODS - 1))
            sel_idx = SEL_W'(NUM_PERIODS - 1);
        else
            sel_idx = period_sel;
        term = term_tab[sel_idx];
    end

    // Count, wrap at the terminal value, and set the request and the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            nmi_req <= 1'b0;
            tout_n  <= 1'b1;
        end else begin
            nmi_req <= 1'b0;
            if (cnt_clear) begin
                count  <= '0;
                tout_n <= 1'b1;
            end else if (advance) begin
                if (count == term) begin
                    count   <= '0;
                    nmi_req <= 1'b1;
                    tout_n  <= 1'b0;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // R3: the request never lasts two cycles
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R4: the pin is low whenever a request is issued
    p_pin_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> !tout_n);

    // R5: a restart releases the pin and suppresses the request
    p_clear_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> (tout_n && !nmi_req));

    // R10: the count holds when the gate blocks it and there is no restart
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !cnt_clear) |=> $stable(count));

    // R2: the count never passes the terminal value of the selected period
    p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clear |=> (count <= term));

endmodule

// File: rtl/wdog_timer.sv
// Top level of the watchdog timer with selectable period.
// Connects the control register, the mode gate and the timeout counter.
// Assumes all inputs are synchronous to clk. The power manager, the interrupt
//   controller and the CPU are outside this block.
module wdog_timer #(
    parameter int unsigned BASE_EXP    = 15,
    parameter int unsigned EXP_STEP    = 2,
    parameter int unsigned NUM_PERIODS = 6,
    parameter int unsigned KEY_W       = 8,
    parameter logic [KEY_W-1:0] DISABLE_KEY = 8'hB1,
    localparam int unsigned SEL_W      = $clog2(NUM_PERIODS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_run_en,
    input  logic [SEL_W-1:0] wr_period,
    input  logic             wr_idle_run,
    input  logic             wr_clear,
    input  logic [KEY_W-1:0] wr_key,
    input  logic             idle_i,
    input  logic             stop_i,
    input  logic             sleep_i,
    input  logic             slow_i,
    input  logic             dbg_halt_i,
    output logic             nmi_req_o,
    output logic             tout_n_o
);
    import wdog_pkg::*;

    logic             run_en;
    logic [SEL_W-1:0] period_q;
    logic             idle_run_q;
    logic             cnt_clear;
    logic             advance;
    wdog_mode_t       mode;

    // Gather the mode inputs into one struct.
    always_comb begin
        mode.idle  = idle_i;
        mode.stop  = stop_i;
        mode.sleep = sleep_i;
        mode.slow  = slow_i;
        mode.dbg   = dbg_halt_i;
    end

    wdog_ctrl #(
        .SEL_W       (SEL_W),
        .KEY_W       (KEY_W),
        .DISABLE_KEY (DISABLE_KEY)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_run_en   (wr_run_en),
        .wr_period   (wr_period),
        .wr_idle_run (wr_idle_run),
        .wr_clear    (wr_clear),
        .wr_key      (wr_key),
        .run_en      (run_en),
        .period_q    (period_q),
        .idle_run_q  (idle_run_q),
        .cnt_clear   (cnt_clear)
    );

    wdog_gate u_gate (
        .run_en   (run_en),
        .idle_run (idle_run_q),
        .mode     (mode),
        .advance  (advance)
    );

    wdog_counter #(
        .BASE_EXP    (BASE_EXP),
        .EXP_STEP    (EXP_STEP),
        .NUM_PERIODS (NUM_PERIODS),
        .SEL_W       (SEL_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .cnt_clear  (cnt_clear),
        .period_sel (period_q),
        .nmi_req    (nmi_req_o),
        .tout_n     (tout_n_o)
    );

    // R9: the pin cannot fall while a low-power mode stops the counter
    p_lowpower_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i || sleep_i || slow_i) |=> !$fell(tout_n_o));

endmodule

// File: tb/wdog_timer_tb.sv
// Directed bench for wdog_timer. It uses short intervals: 2^(4+2c) cycles.
module wdog_timer_tb;

    localparam int unsigned BASE  = 4;
    localparam int unsigned STEP  = 2;
    localparam logic [7:0]  KEY   = 8'hB1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic       wr_run_en = 1'b1;
    logic [2:0] wr_period = 3'd0;
    logic       wr_idle_run = 1'b0;
    logic       wr_clear = 1'b0;
    logic [7:0] wr_key = 8'h00;
    logic       idle_i = 1'b0, stop_i = 1'b0, sleep_i = 1'b0, slow_i = 1'b0, dbg_halt_i = 1'b0;
    logic       nmi_req_o, tout_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] cur_per = 3'd0;
    logic       cur_idle = 1'b0;

    always #2 clk = ~clk;

    wdog_timer #(.BASE_EXP(BASE), .EXP_STEP(STEP), .DISABLE_KEY(KEY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_run_en(wr_run_en),
        .wr_period(wr_period), .wr_idle_run(wr_idle_run), .wr_clear(wr_clear),
        .wr_key(wr_key), .idle_i(idle_i), .stop_i(stop_i), .sleep_i(sleep_i),
        .slow_i(slow_i), .dbg_halt_i(dbg_halt_i), .nmi_req_o(nmi_req_o),
        .tout_n_o(tout_n_o)
    );

    function automatic int unsigned ivl(input int unsigned code);
        int unsigned c = (code > 5) ? 5 : code;
        return 1 << (BASE + STEP * c);
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Advance n edges and sample 1 ns after the last one.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One write, taken on the next edge.
    task automatic wr(input logic en, input logic [2:0] per, input logic idl,
                      input logic clr, input logic [7:0] key);
        wr_valid = 1'b1; wr_run_en = en; wr_period = per;
        wr_idle_run = idl; wr_clear = clr; wr_key = key;
        tick(1);
        wr_valid = 1'b0; wr_clear = 1'b0;
        cur_per = per; cur_idle = idl;
    endtask

    task automatic restart();
        wr(1'b1, cur_per, cur_idle, 1'b1, 8'h00);
    endtask

    // Expect the pulse after exactly n more counting edges, and not one early.
    task automatic expect_pulse(input string req, input int n);
        tick(n - 1);
        chk(req, "no pulse one cycle early", nmi_req_o, 1'b0);
        tick(1);
        chk(req, "pulse on terminal cycle", nmi_req_o, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk("R1", "irq low in reset", nmi_req_o, 1'b0);
        chk("R1", "pin high in reset", tout_n_o, 1'b1);
        rst_n = 1'b1;
        cur_per = 3'd0; cur_idle = 1'b0;
        expect_pulse("R1", ivl(0));
    endtask

    task automatic t_pulse_pin();
        tick(1);
        chk("R3", "pulse lasts one cycle", nmi_req_o, 1'b0);
        chk("R4", "pin low after timeout", tout_n_o, 1'b0);
        expect_pulse("R3", ivl(0) - 1);
        tick(5);
        chk("R4", "pin still low", tout_n_o, 1'b0);
        restart();
        chk("R5", "clear releases pin", tout_n_o, 1'b1);
    endtask

    task automatic t_periods();
        wr(1'b1, 3'd1, 1'b0, 1'b0, 8'h00);
        expect_pulse("R2", ivl(1));
        wr(1'b1, 3'd2, 1'b0, 1'b0, 8'h00);
        expect_pulse("R2", ivl(2));
        wr(1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        expect_pulse("R2", ivl(7));
    endtask

    task automatic t_period_change();
        wr(1'b1, 3'd1, 1'b0, 1'b1, 8'h00);
        tick(40);
        wr(1'b1, 3'd0, 1'b0, 1'b0, 8'h00);
        expect_pulse("R6", ivl(0));
    endtask

    task automatic t_clear_priority();
        restart();
        tick(ivl(0) - 1);
        restart();
        chk("R5", "clear beats terminal edge", nmi_req_o, 1'b0);
        chk("R5", "pin high after clear", tout_n_o, 1'b1);
        expect_pulse("R5", ivl(0));
    endtask

    task automatic t_disable();
        logic seen;
        restart();
        tick(4);
        wr(1'b0, cur_per, cur_idle, 1'b0, 8'h5A);
        expect_pulse("R7", ivl(0) - 5);
        wr(1'b0, cur_per, cur_idle, 1'b0, KEY);
        chk("R7", "disable releases pin", tout_n_o, 1'b1);
        seen = 1'b0;
        for (int i = 0; i < 100; i++) begin
            tick(1);
            if (nmi_req_o || !tout_n_o) seen = 1'b1;
        end
        chk("R7", "no timeout while disabled", seen, 1'b0);
        wr(1'b1, cur_per, cur_idle, 1'b0, 8'h00);
        expect_pulse("R7", ivl(0));
    endtask

    task automatic t_idle();
        wr(1'b1, 3'd0, 1'b0, 1'b1, 8'h00);
        tick(10);
        idle_i = 1'b1;
        tick(40);
        chk("R8", "held in idle", nmi_req_o, 1'b0);
        idle_i = 1'b0;
        expect_pulse("R8", ivl(0) - 10);
        wr(1'b1, 3'd0, 1'b1, 1'b1, 8'h00);
        idle_i = 1'b1;
        expect_pulse("R8", ivl(0));
        idle_i = 1'b0;
    endtask

    task automatic t_lowpower();
        restart();
        tick(5);
        idle_i = 1'b1; stop_i = 1'b1;
        tick(50);
        stop_i = 1'b0;
        tick(3);
        sleep_i = 1'b1;
        tick(20);
        sleep_i = 1'b0; slow_i = 1'b1;
        tick(20);
        slow_i = 1'b0;
        chk("R9", "no pulse under low-power modes", tout_n_o, 1'b1);
        expect_pulse("R9", ivl(0) - 8);
        idle_i = 1'b0;
    endtask

    task automatic t_debug();
        restart();
        tick(7);
        dbg_halt_i = 1'b1;
        tick(30);
        chk("R10", "frozen in debug", tout_n_o, 1'b1);
        dbg_halt_i = 1'b0;
        expect_pulse("R10", ivl(0) - 7);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_pulse_pin();
                t_periods();
                t_period_change();
                t_clear_priority();
                t_disable();
                t_idle();
                t_lowpower();
                t_debug();
            end
            begin
                repeat (190000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule